// File: doc/BRIEF.md
# Configurable Output Logic Cell

This block is one output cell of a small programmable logic device. Two sum terms arrive already evaluated from the logic array. Each sum term feeds one of two storage registers. Each register can be set to capture its input (D behaviour) or to toggle when its input is 1 (T behaviour). Each register is advanced by a clock source chosen by a static bit: its own product-term clock or the shared clock pin.

Each register has its own clearing product term. All registers share one synchronous set line. A test path can load any register value directly. Both register values always return to the array as feedback. The pad value comes either straight from the logic function or from register 0. An enable flag stands in for the tri-state control of the pad.

All logic runs on one system clock `clk`, and `rst` is the power-up reset. The selected clock source is sampled on `clk`. A low-to-high change of that source counts as an active edge, and the register updates on the `clk` edge where the source is first seen high. A source that is already high when `rst` is released therefore counts as an edge on the first `clk` edge. In registered mode `pad_out` is `fb[0]` itself and adds no further cycle of delay.

Top module: `pld_out_cell`

## Requirements
- R1: While `rst` is high, both registers go to 0 on every `clk` edge, so `fb` reads 2'b00. With `cfg_reg`=1, `pad_out` then reads 0.
- R2: An active edge for register i is a 0-to-1 change of its selected clock source, seen between two consecutive `clk` edges. The source is `pin_clk` when `cfg_pin[i]`=1 and `pt_clk[i]` when `cfg_pin[i]`=0. Edges on the source that is not selected, falling edges and steady levels have no effect: the register holds its value.
- R3: With `cfg_t[i]`=0 (D), register i takes its data input on an active edge.
- R4: With `cfg_t[i]`=1 (T), register i inverts on an active edge when its data input is 1, and holds when the data input is 0.
- R5: `pt_ar[i]`=1 clears register i on the next `clk` edge. This happens with or without an active edge, and it takes priority over preload, preset and update.
- R6: `pl_en`=1 loads `pl_val[i]` into register i on the next `clk` edge. Clock edges, preset and data are then ignored. Only `pt_ar[i]` overrides it.
- R7: With `gsp`=1, an active edge sets the register to 1 whatever its data and mode are. Without an active edge `gsp` has no effect.
- R8: With `cfg_join`=1, the data input of register 0 and the logic function are `sum[0] | sum[1]`. With `cfg_join`=0 they are `sum[0]`. Register 1 always takes `sum[1]` and drives only `fb[1]`.
- R9: With `cfg_reg`=0, `pad_out` is the logic function of R8, without any clock delay. With `cfg_reg`=1, `pad_out` equals `fb[0]`.
- R10: `pad_oe` follows `pt_oe` without any clock delay. `fb` shows both registers whatever the value of `pt_oe` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| sum | input | 2 | Evaluated sum terms from the array |
| pt_clk | input | 2 | Clock product term, one per register |
| pin_clk | input | 1 | Shared clock pin |
| pt_ar | input | 2 | Clearing product term, one per register |
| pt_oe | input | 1 | Output enable product term |
| gsp | input | 1 | Shared synchronous preset |
| pl_en | input | 1 | Preload strobe |
| pl_val | input | 2 | Preload values |
| cfg_t | input | 2 | 1 = T behaviour, 0 = D behaviour, per register |
| cfg_pin | input | 2 | 1 = clock from pin, 0 = product-term clock, per register |
| cfg_join | input | 1 | 1 = OR both sum terms into the logic function |
| cfg_reg | input | 1 | 1 = drive register 0 to the pad, 0 = drive the logic function |
| pad_out | output | 1 | Pad data |
| pad_oe | output | 1 | Pad enable flag |
| fb | output | 2 | Register feedback to the array |

## Verification
The register controls can fall in the same cycle. An active clock edge can arrive together with the preset, with a preload, or with a clear. The bench provokes these cases with rising clock sources placed alongside `gsp`, `pl_en` and `pt_ar` in the same vector. It judges them against the priority order of R5, R6 and R7 by reading `fb` after the edge. Mixed clock selection is also covered: one register takes the pin while the other takes its product term, in the same cycle. The bench checks that only the register whose selected source rose changes.

// File: rtl/pld_cell_pkg.sv
package pld_cell_pkg;
  typedef enum logic {FF_CAPTURE = 1'b0, FF_TOGGLE = 1'b1} ff_kind_e;
  typedef enum logic {SRC_TERM = 1'b0, SRC_PIN = 1'b1} clk_src_e;
endpackage

// File: rtl/pld_edge_pick.sv
module pld_edge_pick
  import pld_cell_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  clk_src_e src_sel,
  input  logic     pin_clk,
  input  logic     term_clk,
  output logic     tick
);
  logic src_now;
  logic src_last;

  assign src_now = (src_sel == SRC_PIN) ? pin_clk : term_clk;

  always_ff @(posedge clk) begin
    if (rst) src_last <= 1'b0;
    else     src_last <= src_now;
  end

  assign tick = src_now & ~src_last;

  // R2: one rising change produces a single update slot
  assert_single_tick_R2: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/pld_bit_reg.sv
module pld_bit_reg
  import pld_cell_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  logic     d,
  input  ff_kind_e kind,
  input  logic     clr,
  input  logic     gsp,
  input  logic     pl_en,
  input  logic     pl_val,
  output logic     q
);
  always_ff @(posedge clk) begin
    if (rst)             q <= 1'b0;
    else if (clr)        q <= 1'b0;
    else if (pl_en)      q <= pl_val;
    else if (tick) begin
      if (gsp)                    q <= 1'b1;
      else if (kind == FF_TOGGLE) q <= q ^ d;
      else                        q <= d;
    end
  end

  assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
    clr |=> !q);
  assert_preload_R6: assert property (@(posedge clk) disable iff (rst)
    (!clr && pl_en) |=> (q == $past(pl_val)));
  assert_preset_R7: assert property (@(posedge clk) disable iff (rst)
    (!clr && !pl_en && tick && gsp) |=> q);
  assert_capture_R3: assert property (@(posedge clk) disable iff (rst)
    (!clr && !pl_en && tick && !gsp && kind == FF_CAPTURE) |=> (q == $past(d)));
  assert_toggle_R4: assert property (@(posedge clk) disable iff (rst)
    (!clr && !pl_en && tick && !gsp && kind == FF_TOGGLE) |=> (q == ($past(q) ^ $past(d))));
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!clr && !pl_en && !tick) |=> $stable(q));
endmodule

// File: rtl/pld_term_route.sv
module pld_term_route #(
  parameter int NREG = 2
) (
  input  logic [NREG-1:0] sum,
  input  logic            join_en,
  output logic [NREG-1:0] data
);
  assign data[0] = join_en ? (|sum) : sum[0];

  for (genvar i = 1; i < NREG; i++) begin : g_own
    assign data[i] = sum[i];
  end
endmodule

// File: rtl/pld_out_cell.sv
module pld_out_cell
  import pld_cell_pkg::*;
#(
  parameter int NREG = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NREG-1:0] sum,
  input  logic [NREG-1:0] pt_clk,
  input  logic            pin_clk,
  input  logic [NREG-1:0] pt_ar,
  input  logic            pt_oe,
  input  logic            gsp,
  input  logic            pl_en,
  input  logic [NREG-1:0] pl_val,
  input  logic [NREG-1:0] cfg_t,
  input  logic [NREG-1:0] cfg_pin,
  input  logic            cfg_join,
  input  logic            cfg_reg,
  output logic            pad_out,
  output logic            pad_oe,
  output logic [NREG-1:0] fb
);
  logic [NREG-1:0] data;
  logic [NREG-1:0] tick;

  pld_term_route #(.NREG(NREG)) u_route (
    .sum(sum), .join_en(cfg_join), .data(data)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    pld_edge_pick u_edge (
      .clk(clk), .rst(rst),
      .src_sel(clk_src_e'(cfg_pin[i])),
      .pin_clk(pin_clk), .term_clk(pt_clk[i]),
      .tick(tick[i])
    );
    pld_bit_reg u_bit (
      .clk(clk), .rst(rst), .tick(tick[i]), .d(data[i]),
      .kind(ff_kind_e'(cfg_t[i])), .clr(pt_ar[i]), .gsp(gsp),
      .pl_en(pl_en), .pl_val(pl_val[i]), .q(fb[i])
    );
  end

  assign pad_out = cfg_reg ? fb[0] : data[0];
  assign pad_oe  = pt_oe;

  // R1: reset leaves every register cleared
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (fb == '0));
endmodule

// File: tb/pld_out_cell_tb_top.sv
module pld_out_cell_tb_top;
  typedef struct packed {
    logic [3:0] req;
    logic [1:0] t;
    logic [1:0] pin;
    logic       jn;
    logic       rg;
    logic [1:0] sm;
    logic [1:0] ptc;
    logic       pinc;
    logic [1:0] ar;
    logic       oe;
    logic       gs;
    logic       ple;
    logic [1:0] plv;
    logic [1:0] efb;
    logic       epad;
  } vec_t;

  localparam int NV = 23;
  // req t pin jn rg sum ptc pinc ar oe gsp ple plv | expected fb pad
  localparam vec_t VEC [NV] = '{
    '{4'd3,  2'b00, 2'b00, 1'b0, 1'b1, 2'b01, 2'b11, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 2'b00, 2'b01, 1'b1}, // R3 capture
    '{4'd2,  2'b00, 2'b00, 1'b0, 1'b1, 2'b10, 2'b00, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 2'b00, 2'b01, 1'b1}, // R2 falling edge holds
    '{4'd3,  2'b00, 2'b00, 1'b0, 1'b1, 2'b10, 2'b11, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 2'b00, 2'b10, 1'b0}, // R3
    '{4'd2,  2'b11, 2'b00, 1'b0, 1'b1, 2'b11, 2'b00, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 2'b00, 2'b10, 1'b0}, // R2
    '{4'd4,  2'b11, 2'b00, 1'b0, 1'b1, 2'b11, 2'b11, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 2'b00, 2'b01, 1'b1}, // R4 toggle both
    '{4'd2,  2'b11, 2'b00, 1'b0, 1'b1, 2'b01, 2'b00, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 2'b00, 2'b01, 1'b1}, // R2
    '{4'd4,  2'b11, 2'b00, 1'b0, 1'b1, 2'b01, 2'b11, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0}, // R4 hold on 0
    '{4'd2,  2'b00, 2'b11, 1'b0, 1'b1, 2'b11, 2'b00, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0}, // R2
    '{4'd2,  2'b00, 2'b11, 1'b0, 1'b1, 2'b11, 2'b11, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0}, // R2 unselected edge
    '{4'd2,  2'b00, 2'b11, 1'b0, 1'b1, 2'b11, 2'b11, 1'b1, 2'b00, 1'b1, 1'b0, 1'b0, 2'b00, 2'b11, 1'b1}, // R2 pin edge
    '{4'd2,  2'b00, 2'b01, 1'b0, 1'b1, 2'b00, 2'b00, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 2'b00, 2'b11, 1'b1}, // R2
    '{4'd2,  2'b00, 2'b01, 1'b0, 1'b1, 2'b00, 2'b10, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 2'b00, 2'b01, 1'b1}, // R2 mixed select
    '{4'd7,  2'b00, 2'b00, 1'b0, 1'b1, 2'b00, 2'b00, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 2'b00, 2'b01, 1'b1}, // R7 no edge
    '{4'd7,  2'b00, 2'b00, 1'b0, 1'b1, 2'b00, 2'b11, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 2'b00, 2'b11, 1'b1}, // R7 preset
    '{4'd6,  2'b00, 2'b00, 1'b0, 1'b1, 2'b00, 2'b00, 1'b0, 2'b00, 1'b1, 1'b0, 1'b1, 2'b10, 2'b10, 1'b0}, // R6
    '{4'd6,  2'b00, 2'b00, 1'b0, 1'b1, 2'b11, 2'b11, 1'b0, 2'b00, 1'b1, 1'b1, 1'b1, 2'b01, 2'b01, 1'b1}, // R6 over edge+preset
    '{4'd5,  2'b00, 2'b00, 1'b0, 1'b1, 2'b00, 2'b00, 1'b0, 2'b11, 1'b1, 1'b0, 1'b1, 2'b11, 2'b00, 1'b0}, // R5 over preload
    '{4'd6,  2'b00, 2'b00, 1'b0, 1'b1, 2'b00, 2'b00, 1'b0, 2'b00, 1'b1, 1'b0, 1'b1, 2'b11, 2'b11, 1'b1}, // R6
    '{4'd5,  2'b00, 2'b00, 1'b0, 1'b1, 2'b11, 2'b11, 1'b0, 2'b01, 1'b1, 1'b0, 1'b0, 2'b00, 2'b10, 1'b0}, // R5 over edge
    '{4'd9,  2'b00, 2'b00, 1'b1, 1'b0, 2'b10, 2'b00, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 2'b00, 2'b10, 1'b1}, // R9 R8 joined comb
    '{4'd8,  2'b00, 2'b00, 1'b0, 1'b0, 2'b10, 2'b00, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 2'b00, 2'b10, 1'b0}, // R8 separate comb
    '{4'd8,  2'b00, 2'b00, 1'b1, 1'b1, 2'b10, 2'b11, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 2'b00, 2'b11, 1'b1}, // R8 joined registered
    '{4'd10, 2'b00, 2'b00, 1'b0, 1'b1, 2'b10, 2'b00, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 2'b00, 2'b11, 1'b1}  // R10 oe low
  };

  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] sum, pt_clk, pt_ar, pl_val, cfg_t, cfg_pin, fb;
  logic       pin_clk, pt_oe, gsp, pl_en, cfg_join, cfg_reg, pad_out, pad_oe;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  pld_out_cell dut_i (
    .clk(clk), .rst(rst), .sum(sum), .pt_clk(pt_clk), .pin_clk(pin_clk),
    .pt_ar(pt_ar), .pt_oe(pt_oe), .gsp(gsp), .pl_en(pl_en), .pl_val(pl_val),
    .cfg_t(cfg_t), .cfg_pin(cfg_pin), .cfg_join(cfg_join), .cfg_reg(cfg_reg),
    .pad_out(pad_out), .pad_oe(pad_oe), .fb(fb)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    sum = 2'b00; pt_clk = 2'b00; pin_clk = 1'b0; pt_ar = 2'b00; pt_oe = 1'b1;
    gsp = 1'b0; pl_en = 1'b0; pl_val = 2'b00; cfg_t = 2'b00; cfg_pin = 2'b00;
    cfg_join = 1'b0; cfg_reg = 1'b1;
  endtask

  initial begin
    idle();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset fb", fb, 0);
    chk("R1 reset pad", pad_out, 0);
    @(negedge clk);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      cfg_t = VEC[v].t; cfg_pin = VEC[v].pin; cfg_join = VEC[v].jn; cfg_reg = VEC[v].rg;
      sum = VEC[v].sm; pt_clk = VEC[v].ptc; pin_clk = VEC[v].pinc; pt_ar = VEC[v].ar;
      pt_oe = VEC[v].oe; gsp = VEC[v].gs; pl_en = VEC[v].ple; pl_val = VEC[v].plv;
      @(posedge clk);
      #1;
      chk($sformatf("R%0d vec %0d fb", VEC[v].req, v), fb, VEC[v].efb);
      chk($sformatf("R%0d vec %0d pad_out", VEC[v].req, v), pad_out, VEC[v].epad);
      chk($sformatf("R10 vec %0d pad_oe", v), pad_oe, VEC[v].oe);
    end

    // R1: reset in mid-run overrides an edge and preset arriving at once
    @(negedge clk);
    idle();
    pt_clk = 2'b11; gsp = 1'b1; rst = 1'b1;
    @(posedge clk);
    #1;
    chk("R1 mid-run reset fb", fb, 0);
    @(negedge clk);
    rst = 1'b0; pt_clk = 2'b00; gsp = 1'b0;

    // R9: combinational pad follows the sum term without a clock edge
    cfg_reg = 1'b0; sum = 2'b01;
    #1;
    chk("R9 comb pad follows sum", pad_out, 1);
    sum = 2'b00;
    #1;
    chk("R9 comb pad low", pad_out, 0);
    @(posedge clk);
    #1;
    chk("R9 fb untouched", fb, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule